// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block is the digital controller that sits in front of a successive-approximation converter core. Software programs it through a small register bus. The block selects an analog input channel, pulses a start request to the core and waits for the core's done pulse. It then formats the raw code and writes it into one of eight result slots. A sequence is one to eight conversions long. It either repeats a single channel or scans upward from a chosen channel, wrapping modulo eight. It runs once or restarts forever, and it can be gated by an external trigger edge.

Each stored result is either the full 10-bit code or its upper 8 bits. It is placed left- or right-justified in a 16-bit word, as offset binary or as two's complement (the sign bit is inverted and, when right-justified, extended). Status shows sequence completion, a trigger overrun, a slot overrun, the index of the next slot and one completion bit per slot. Sequence completion can raise an interrupt. Writes to the control registers abort the sequence in flight. Only the mode register also starts a new sequence. The sequencer holds off conversions after power-up, and after a stop request, until a recovery delay has passed.

Top module: `adc_seq_ctrl`

Register map (4-bit word address; result slots occupy addresses 8 to 15):
- 0 PWR: bit0 power on, bit1 interrupt enable, bit2 trigger enable
- 1 LEN: bits[2:0] = conversions per sequence minus one
- 2 RES: bit0 = 1 selects 8-bit, 0 selects 10-bit
- 3 MODE: bits[2:0] first channel, bit3 scan, bit4 continuous, bit5 right-justify, bit6 signed
- 4 STAT0: bit0 sequence done, bit1 trigger overrun, bit2 slot overrun, bits[6:4] next slot index; writing 1 to bits 0..2 clears them
- 5 STAT1: bits[7:0] per-slot completion flags

## Requirements
- R1: After reset all configuration fields, STAT0, STAT1, irq and conv_start are 0.
- R2: A write to PWR, LEN or RES (address 0, 1 or 2) aborts a sequence in flight. It starts no new one, sets no done flag, and a core result that arrives late is discarded.
- R3: A write to MODE (address 3) aborts any sequence and starts a new one, and conv_start is a single-cycle pulse for each conversion.
- R4: No conv_start is issued until PWR bit0 has been 1 for RECOVERY_CYC cycles. While stop_req is high, any sequence is aborted, and the recovery delay restarts after stop_req falls.
- R5: Conversion k of a sequence (k from 0 to LEN) uses channel (first+k) mod 8 in scan mode, or the first channel otherwise, and is written to result slot k.
- R6: RES bit0 = 0 stores the 10-bit code conv_data[9:0]; RES bit0 = 1 stores the 8-bit code conv_data[9:2].
- R7: A left-justified code sits in the top bits of the 16-bit slot with zeros below. A right-justified code sits in the bottom bits. The signed format inverts the code's top bit and, when right-justified, sign-extends it.
- R8: In continuous mode (MODE bit4) a new sequence starts after the last conversion without any write. Storing into a slot whose completion flag is still set raises STAT0 bit2.
- R9: STAT1 bit k is set when slot k is written and cleared when slot k is read. STAT0 bits[6:4] give the next slot index, and STAT0 bit0 is set when a sequence completes.
- R10: irq equals PWR bit1 AND STAT0 bit0.
- R11: With PWR bit2 set, every sequence waits for a rising edge on ext_trig before its first conversion. A rising edge while no sequence is waiting sets STAT0 bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, data one cycle later |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data |
| ext_trig | input | 1 | External trigger, synchronous to clk |
| stop_req | input | 1 | Stop request, aborts and holds off conversions |
| conv_start | output | 1 | Start pulse to the converter core |
| conv_chan | output | 3 | Channel select to the input multiplexer |
| conv_done | input | 1 | Core result-valid pulse |
| conv_data | input | 10 | Raw offset-binary code from the core |
| irq | output | 1 | Sequence-complete interrupt |

## Verification
The hardest situation to reach is an abort that lands while the core is still converting, followed by the core's late result. The bench's core model takes a budget of conversions it may finish. With a budget of one, the sequencer stays parked mid-sequence with one slot stored and the next conversion outstanding. The slot index and flags are read there. A LEN write or a stop request then aborts the sequence, and the budget is released so the stale result arrives after the abort. The completion flags and the start count show that the result was discarded and that nothing restarted. Continuous overrun is reached the same way: the slots are left unread while the sequencer restarts several times.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [3:0] A_PWR   = 4'd0;
  localparam logic [3:0] A_LEN   = 4'd1;
  localparam logic [3:0] A_RES   = 4'd2;
  localparam logic [3:0] A_MODE  = 4'd3;
  localparam logic [3:0] A_STAT0 = 4'd4;
  localparam logic [3:0] A_STAT1 = 4'd5;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_WAIT} seq_state_e;
endpackage

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
  parameter int RAW_W = 10,
  parameter int DW    = 16
) (
  input  logic [RAW_W-1:0] raw,
  input  logic             res_low,
  input  logic             right,
  input  logic             sgn,
  output logic [DW-1:0]    result
);
  localparam int LO_W = RAW_W - 2;

  logic [RAW_W-1:0] full_code;
  logic [LO_W-1:0]  short_code;

  always_comb begin
    full_code  = raw;
    full_code[RAW_W-1] = raw[RAW_W-1] ^ sgn;
    short_code = raw[RAW_W-1:2];
    short_code[LO_W-1] = raw[RAW_W-1] ^ sgn;
    if (res_low) begin
      if (!right)   result = {short_code, {(DW-LO_W){1'b0}}};
      else if (sgn) result = {{(DW-LO_W){short_code[LO_W-1]}}, short_code};
      else          result = {{(DW-LO_W){1'b0}}, short_code};
    end else begin
      if (!right)   result = {full_code, {(DW-RAW_W){1'b0}}};
      else if (sgn) result = {{(DW-RAW_W){full_code[RAW_W-1]}}, full_code};
      else          result = {{(DW-RAW_W){1'b0}}, full_code};
    end
  end

  always_comb begin
    if (!right && !res_low)
      a_left_sign_r7: assert (result[DW-1] == (raw[RAW_W-1] ^ sgn));
  end
endmodule

// File: rtl/adc_seq_mem.sv
module adc_seq_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            abort,
  input  logic            go,
  input  logic            power_ok,
  input  logic            trig_en,
  input  logic            trig_edge,
  input  logic            multi,
  input  logic            cont,
  input  logic [CH_W-1:0] start_ch,
  input  logic [CH_W-1:0] last_idx,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan,
  output logic            store,
  output logic [CH_W-1:0] slot,
  output logic            seq_end,
  output logic            armed
);
  seq_state_e      state;
  logic [CH_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cnt        <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= 1'b0;
      if (go) begin
        state <= S_ARM;
        cnt   <= '0;
      end else if (abort) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          S_ARM: if (power_ok && (!trig_en || trig_edge)) begin
            state      <= S_WAIT;
            conv_start <= 1'b1;
            conv_chan  <= start_ch;
          end
          S_WAIT: if (conv_done) begin
            if (cnt == last_idx) begin
              cnt   <= '0;
              state <= cont ? S_ARM : S_IDLE;
            end else begin
              cnt        <= cnt + 1'b1;
              conv_start <= 1'b1;
              conv_chan  <= multi ? start_ch + cnt + 1'b1 : start_ch;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign store   = (state == S_WAIT) && conv_done && !abort && !go;
  assign slot    = cnt;
  assign seq_end = store && (cnt == last_idx);
  assign armed   = (state == S_ARM);

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !conv_done) |=> !conv_start);
  p_abort_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (abort && !go) |=> (!conv_start && !armed));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH          = 8,
  parameter int RAW_W        = 10,
  parameter int DW           = 16,
  parameter int RECOVERY_CYC = 480,
  localparam int CH_W        = $clog2(NCH),
  localparam int REC_W       = $clog2(RECOVERY_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [3:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            ext_trig,
  input  logic            stop_req,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan,
  input  logic            conv_done,
  input  logic [RAW_W-1:0] conv_data,
  output logic            irq
);
  logic            cfg_pwr, cfg_irq_en, cfg_trig_en, cfg_res8;
  logic            cfg_multi, cfg_cont, cfg_right, cfg_sgn;
  logic [CH_W-1:0] cfg_last, cfg_start;
  logic [REC_W-1:0] rec_cnt;
  logic            trig_q, trig_edge, power_ok;
  logic            go, abort, wr_cfg;
  logic            store, seq_end, armed;
  logic [CH_W-1:0] slot;
  logic [DW-1:0]   fmt_val, mem_q, reg_q;
  logic            sel_mem_q;
  logic            seq_done, trig_ovr, slot_ovr;
  logic [NCH-1:0]  slot_flags;
  logic            rd_slot;
  logic            unused_bits;

  assign unused_bits = ^{bus_wdata[7]};
  assign wr_cfg = bus_wr && (bus_addr == A_PWR || bus_addr == A_LEN ||
                             bus_addr == A_RES || bus_addr == A_MODE);
  assign go     = bus_wr && (bus_addr == A_MODE) && !stop_req;
  assign abort  = wr_cfg || stop_req;
  assign rd_slot = bus_rd && bus_addr[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      {cfg_pwr, cfg_irq_en, cfg_trig_en, cfg_res8} <= '0;
      {cfg_multi, cfg_cont, cfg_right, cfg_sgn}    <= '0;
      cfg_last  <= '0;
      cfg_start <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_PWR:  {cfg_trig_en, cfg_irq_en, cfg_pwr} <= bus_wdata[2:0];
        A_LEN:  cfg_last <= bus_wdata[CH_W-1:0];
        A_RES:  cfg_res8 <= bus_wdata[0];
        A_MODE: begin
          cfg_start <= bus_wdata[CH_W-1:0];
          {cfg_sgn, cfg_right, cfg_cont, cfg_multi} <= bus_wdata[6:3];
        end
        default: ;
      endcase
    end
  end

  // recovery delay after power-up and after a stop request
  always_ff @(posedge clk) begin
    if (rst || !cfg_pwr || stop_req) rec_cnt <= '0;
    else if (rec_cnt != REC_W'(RECOVERY_CYC)) rec_cnt <= rec_cnt + 1'b1;
  end
  assign power_ok = cfg_pwr && !stop_req && (rec_cnt == REC_W'(RECOVERY_CYC));

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= ext_trig;
  end
  assign trig_edge = ext_trig && !trig_q;

  adc_seq_fsm #(.NCH(NCH)) u_fsm (
    .clk(clk), .rst(rst), .abort(abort), .go(go), .power_ok(power_ok),
    .trig_en(cfg_trig_en), .trig_edge(trig_edge), .multi(cfg_multi),
    .cont(cfg_cont), .start_ch(cfg_start), .last_idx(cfg_last),
    .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
    .store(store), .slot(slot), .seq_end(seq_end), .armed(armed)
  );

  adc_seq_fmt #(.RAW_W(RAW_W), .DW(DW)) u_fmt (
    .raw(conv_data), .res_low(cfg_res8), .right(cfg_right), .sgn(cfg_sgn),
    .result(fmt_val)
  );

  adc_seq_mem #(.DEPTH(NCH), .DW(DW)) u_mem (
    .clk(clk), .we(store), .waddr(slot), .wdata(fmt_val),
    .re(rd_slot), .raddr(bus_addr[CH_W-1:0]), .rdata(mem_q)
  );

  // status flags: set beats clear
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_done   <= 1'b0;
      trig_ovr   <= 1'b0;
      slot_ovr   <= 1'b0;
      slot_flags <= '0;
    end else begin
      if (bus_wr && bus_addr == A_STAT0) begin
        if (bus_wdata[0]) seq_done <= 1'b0;
        if (bus_wdata[1]) trig_ovr <= 1'b0;
        if (bus_wdata[2]) slot_ovr <= 1'b0;
      end
      if (rd_slot) slot_flags[bus_addr[CH_W-1:0]] <= 1'b0;
      if (store) begin
        slot_flags[slot] <= 1'b1;
        if (slot_flags[slot]) slot_ovr <= 1'b1;
      end
      if (seq_end) seq_done <= 1'b1;
      if (trig_edge && cfg_trig_en && !armed) trig_ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_mem_q <= 1'b0;
    end else if (bus_rd) begin
      sel_mem_q <= bus_addr[3];
      reg_q     <= '0;
      case (bus_addr)
        A_PWR:   reg_q[2:0] <= {cfg_trig_en, cfg_irq_en, cfg_pwr};
        A_LEN:   reg_q[CH_W-1:0] <= cfg_last;
        A_RES:   reg_q[0] <= cfg_res8;
        A_MODE:  reg_q[6:0] <= {cfg_sgn, cfg_right, cfg_cont, cfg_multi, cfg_start};
        A_STAT0: begin
          reg_q[2:0]      <= {slot_ovr, trig_ovr, seq_done};
          reg_q[4 +: CH_W] <= slot;
        end
        A_STAT1: reg_q[NCH-1:0] <= slot_flags;
        default: ;
      endcase
    end
  end

  assign bus_rdata = sel_mem_q ? mem_q : reg_q;
  assign irq       = cfg_irq_en && seq_done;

  p_no_start_unpowered_r4: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(power_ok));
  p_single_channel_r5: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !cfg_multi) |-> (conv_chan == cfg_start));
  p_slot_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    store |=> slot_flags[$past(slot)]);
  p_irq_on_end_r10: assert property (@(posedge clk) disable iff (rst)
    (seq_end && cfg_irq_en) |=> irq);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int REC = 16;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_trig = 1'b0, stop_req = 1'b0;
  logic        conv_start, conv_done;
  logic [2:0]  conv_chan;
  logic [9:0]  conv_data;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  int n_starts = 0, cyc = 0;
  int core_allow = 1000000;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.RECOVERY_CYC(REC)) u_adc_seq_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_trig(ext_trig), .stop_req(stop_req), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .irq(irq)
  );

  function automatic int raw_of(int ch);
    return ch * 113 + 41;
  endfunction

  function automatic logic [15:0] exp_fmt(int raw, bit res8, bit right, bit sgn);
    int v, w;
    w = res8 ? 8 : 10;
    v = res8 ? raw / 4 : raw;
    if (sgn) v = v ^ (1 << (w - 1));
    if (!right) return 16'(v << (16 - w));
    if (sgn && v >= (1 << (w - 1))) return 16'(v - (1 << w));
    return 16'(v);
  endfunction

  // converter core model with a budget of conversions it may finish
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (conv_start) begin
        automatic int ch = int'(conv_chan);
        while (core_allow == 0) @(negedge clk);
        core_allow--;
        repeat (LAT) @(negedge clk);
        conv_data = 10'(raw_of(ch));
        conv_done = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (conv_start) n_starts++;
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: act=running exp=finished");
    finish_run();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 400 && !s[0]; i++) rd(4'd4, s);
    chk(s[0], tag, int'(s[0]), 1);
  endtask

  task automatic wait_start(input int n0, input string tag);
    for (int i = 0; i < 200 && n_starts == n0; i++) @(negedge clk);
    chk(n_starts > n0, tag, n_starts - n0, 1);
  endtask

  // {first ch[9:7], scan[6], len-1[5:3], res8[2], right[1], signed[0]}
  localparam logic [9:0] VECS [6] = '{
    {3'd0, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0},
    {3'd5, 1'b1, 3'd4, 1'b0, 1'b1, 1'b1},
    {3'd3, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0},
    {3'd6, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1},
    {3'd2, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0},
    {3'd7, 1'b0, 3'd1, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    logic [15:0] d;
    int t0, n0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'd4, d); chk(d == 16'h0, "R1 STAT0 after reset", d, 0);
    rd(4'd5, d); chk(d == 16'h0, "R1 STAT1 after reset", d, 0);
    rd(4'd3, d); chk(d == 16'h0, "R1 MODE after reset", d, 0);
    chk(irq == 1'b0 && conv_start == 1'b0, "R1 irq/conv_start after reset", {irq, conv_start}, 0);

    // R4 recovery delay
    wr(4'd0, 8'h01);
    t0 = cyc;
    n0 = n_starts;
    wr(4'd3, 8'h01);
    wait_start(n0, "R4 first start after power-up");
    chk(cyc - t0 >= REC, "R4 recovery delay respected", cyc - t0, REC);
    wait_done("R9 done after first sequence");
    rd(4'd8, d); chk(d == exp_fmt(raw_of(1), 0, 0, 0), "R6 10-bit left unsigned ch1", d, exp_fmt(raw_of(1), 0, 0, 0));
    chk(irq == 1'b0, "R10 no irq when disabled", irq, 0);
    wr(4'd4, 8'h07);

    // R3 R5 R6 R7 R9: table of formats, channel patterns and lengths
    foreach (VECS[v]) begin
      automatic int st = int'(VECS[v][9:7]);
      automatic bit sc = VECS[v][6];
      automatic int ln = int'(VECS[v][5:3]) + 1;
      automatic bit r8 = VECS[v][2];
      automatic bit rj = VECS[v][1];
      automatic bit sg = VECS[v][0];
      n0 = n_starts;
      wr(4'd2, {7'd0, r8});
      wr(4'd1, 8'(ln - 1));
      wr(4'd3, {1'b0, sg, rj, 1'b0, sc, 3'(st)});
      wait_done("R3 sequence completes");
      chk(n_starts - n0 == ln, "R3 one start per conversion", n_starts - n0, ln);
      rd(4'd5, d); chk(d == 16'((1 << ln) - 1), "R9 slot flags after sequence", d, (1 << ln) - 1);
      rd(4'd4, d); chk(d[6:4] == 3'd0, "R9 slot index wraps to 0", d[6:4], 0);
      for (int k = 0; k < ln; k++) begin
        automatic int ch = sc ? (st + k) % 8 : st;
        automatic logic [15:0] e = exp_fmt(raw_of(ch), r8, rj, sg);
        rd(4'(8 + k), d);
        chk(d == e, "R5 R6 R7 slot content", d, e);
      end
      rd(4'd5, d); chk(d == 16'h0, "R9 slot read clears flags", d, 0);
      wr(4'd4, 8'h07);
    end

    // R10 interrupt
    wr(4'd0, 8'h03);
    wr(4'd2, 8'h00);
    wr(4'd1, 8'h00);
    chk(irq == 1'b0, "R10 irq low before completion", irq, 0);
    wr(4'd3, 8'h04);
    wait_done("R10 sequence done");
    chk(irq == 1'b1, "R10 irq on completion", irq, 1);
    wr(4'd4, 8'h01);
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq clears with done flag", irq, 0);
    rd(4'd8, d);

    // R2 abort by LEN write with a conversion outstanding
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h03);
    core_allow = 1;
    wr(4'd3, 8'h08);
    repeat (40) @(negedge clk);
    rd(4'd4, d); chk(d[6:4] == 3'd1 && d[0] == 1'b0, "R9 slot index mid-sequence", d, 16'h0010);
    rd(4'd5, d); chk(d == 16'h1, "R9 one slot stored mid-sequence", d, 1);
    wr(4'd1, 8'h03);
    n0 = n_starts;
    core_allow = 1000000;
    repeat (40) @(negedge clk);
    rd(4'd5, d); chk(d == 16'h1, "R2 late result discarded", d, 1);
    rd(4'd4, d); chk(d[0] == 1'b0, "R2 no done after abort", d[0], 0);
    chk(n_starts == n0, "R2 no restart after abort", n_starts - n0, 0);
    rd(4'd8, d);
    wr(4'd4, 8'h07);

    // R8 continuous mode restarts and overruns
    n0 = n_starts;
    wr(4'd1, 8'h01);
    wr(4'd3, 8'h18);
    for (int i = 0; i < 300 && n_starts - n0 < 6; i++) @(negedge clk);
    chk(n_starts - n0 >= 6, "R8 continuous restart", n_starts - n0, 6);
    rd(4'd4, d); chk(d[2] == 1'b1 && d[0] == 1'b1, "R8 slot overrun flagged", d[2:0], 5);
    wr(4'd0, 8'h01);
    n0 = n_starts;
    repeat (40) @(negedge clk);
    chk(n_starts == n0, "R2 PWR write stops continuous run", n_starts - n0, 0);
    rd(4'd8, d); rd(4'd9, d);
    wr(4'd4, 8'h07);

    // R11 external trigger
    wr(4'd0, 8'h05);
    wr(4'd1, 8'h00);
    n0 = n_starts;
    wr(4'd3, 8'h02);
    repeat (30) @(negedge clk);
    chk(n_starts == n0, "R11 waits for trigger", n_starts - n0, 0);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    wait_start(n0, "R11 trigger starts sequence");
    wait_done("R11 triggered sequence done");
    rd(4'd8, d); chk(d == exp_fmt(raw_of(2), 0, 0, 0), "R11 triggered result", d, exp_fmt(raw_of(2), 0, 0, 0));
    rd(4'd4, d); chk(d[1] == 1'b0, "R11 no overrun on armed trigger", d[1], 0);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    rd(4'd4, d); chk(d[1] == 1'b1, "R11 trigger overrun when idle", d[1], 1);
    wr(4'd4, 8'h07);

    // R4 stop request aborts and re-arms recovery
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h03);
    core_allow = 1;
    wr(4'd3, 8'h08);
    repeat (40) @(negedge clk);
    stop_req = 1'b1;
    repeat (3) @(negedge clk);
    core_allow = 1000000;
    repeat (10) @(negedge clk);
    stop_req = 1'b0;
    n0 = n_starts;
    repeat (40) @(negedge clk);
    chk(n_starts == n0, "R4 stop aborts without restart", n_starts - n0, 0);
    rd(4'd4, d); chk(d[0] == 1'b0, "R4 no done after stop", d[0], 0);
    rd(4'd8, d);
    wr(4'd1, 8'h00);
    t0 = cyc;
    wr(4'd3, 8'h06);
    wait_start(n0, "R4 restart after stop");
    wait_done("R4 sequence after stop completes");
    rd(4'd8, d); chk(d == exp_fmt(raw_of(6), 0, 0, 0), "R4 result after stop", d, exp_fmt(raw_of(6), 0, 0, 0));

    finish_run();
  end
endmodule